// File: doc/BRIEF.md
# Bipolar Return-to-Zero Sample Encoder

This block turns a stream of unsigned pixel values into signed drive codes for a DAC that swings an electro-optic modulator around its bias point. Each pixel is re-centred so that mid-scale gives zero drive. It is then scaled to the full code width and played out over one or more DAC ticks, following a format picked per pixel.

Three formats are available. The level format emits the code once. The doubled format emits the code and then its sign-inverted copy, so that long runs of same-sign data carry no DC content. This halves the useful sample rate relative to the DAC tick rate. The return-to-zero format emits the code, a zero, the inverted code and a zero. Each pulse thus fills only the first half of its slot, which makes one symbol largely independent of the one before it. The DAC ticks at 2.5 MHz in the intended system. The block itself only counts ticks of its clock.

Pixels arrive over a valid/ready handshake. The block takes a new pixel only on the last tick of the current one, or when it is idle. With nothing in progress it drives zero.

Top module: `bipolar_rz_encoder`

## Requirements
- R1: With fmt_sel = 0 (level), an accepted pixel produces its code for exactly one tick, and pixels presented back to back follow each other with no gap.
- R2: With fmt_sel = 1 (doubled), an accepted pixel produces its code for one tick and then the inverted code for one tick.
- R3: With fmt_sel = 2 or 3 (return-to-zero), an accepted pixel produces four ticks in the order code, zero, inverted code, zero.
- R4: A pixel p (8 bits) maps to the 14-bit two's-complement code (p - 128) * 64. Pixel 128 gives 0, pixel 0 gives -8192 and pixel 255 gives 8128.
- R5: The inverted code is the two's-complement negation of the code, except that -8192 inverts to +8191.
- R6: pix_ready is high when no pixel is in progress, or on the final tick of the current pixel's sequence, and low otherwise. A pixel is accepted at a rising clock edge with pix_valid and pix_ready both high, and its first tick appears in the following cycle.
- R7: fmt_sel is sampled only when a pixel is accepted. Changing it while a pixel is in progress does not alter that pixel's sequence.
- R8: During and after reset, and whenever no pixel is in progress, dac_code is 0 and pix_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Output format: 0 level, 1 doubled, 2 or 3 return-to-zero |
| pix_valid | input | 1 | Pixel present on pix_data |
| pix_data | input | 8 | Unsigned pixel value |
| pix_ready | output | 1 | Encoder will take a pixel at the next edge |
| dac_code | output | 14 | Signed two's-complement DAC code for this tick |

## Verification
A slot counter that runs one step off, or a format latched at the wrong moment, shows up at once as a zero tick in the wrong place or a missing inverted pulse. It also moves pix_ready by a cycle, which changes when the next pixel starts. A stale pixel register repeats the previous code at the first tick after acceptance. A bad inversion shows on the second or third tick of the same pixel. The bench compares both outputs against a behavioural model on every tick, so any such fault is reported within the cycle it first reaches the ports.

// File: rtl/brz_pkg.sv
package brz_pkg;

  // Width of the per-pixel tick counter (longest sequence is four ticks).
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    FMT_LEVEL  = 2'd0,
    FMT_DOUBLE = 2'd1,
    FMT_RZ     = 2'd2,
    FMT_RZ_ALT = 2'd3
  } fmt_e;

  // Index of the final tick of a pixel for a given format.
  function automatic logic [SLOT_W-1:0] final_slot(input fmt_e f);
    logic [SLOT_W-1:0] r;
    case (f)
      FMT_LEVEL:  r = 2'd0;
      FMT_DOUBLE: r = 2'd1;
      default:    r = 2'd3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/brz_code_map.sv
// Pixel to signed code mapping plus saturating inversion.
module brz_code_map #(
  parameter int PIX_W  = 8,
  parameter int CODE_W = 14
) (
  input  logic [PIX_W-1:0]  pix,
  output logic [CODE_W-1:0] pos_code,
  output logic [CODE_W-1:0] neg_code
);

  localparam int SHIFT = CODE_W - PIX_W;
  localparam logic [CODE_W-1:0] MOST_NEG = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] MOST_POS = {1'b0, {(CODE_W-1){1'b1}}};

  // Subtracting mid-scale from an unsigned value equals flipping its MSB
  // and reading the result as two's complement.
  logic [PIX_W-1:0] centred;
  assign centred = {~pix[PIX_W-1], pix[PIX_W-2:0]};

  generate
    if (SHIFT > 0) begin : g_scale
      assign pos_code = {centred, {SHIFT{1'b0}}};
    end else begin : g_noscale
      assign pos_code = centred[PIX_W-1 -: CODE_W];
    end
  endgenerate

  always_comb begin
    if (pos_code == MOST_NEG) begin
      neg_code = MOST_POS;
    end else begin
      neg_code = (~pos_code) + {{(CODE_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/brz_slot_seq.sv
// Per-pixel tick sequencer: tracks busy, slot index and latched format.
module brz_slot_seq
  import brz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        fmt_in,
  output logic              in_ready,
  output logic              accept,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output fmt_e              fmt
);

  logic              busy_d;
  logic [SLOT_W-1:0] slot_d;
  logic              at_final;
  logic              fmt_en;

  assign at_final = busy && (slot == final_slot(fmt));
  assign in_ready = !busy || at_final;
  assign accept   = in_valid && in_ready;
  assign fmt_en   = accept;

  always_comb begin
    busy_d = busy;
    slot_d = slot;
    if (accept) begin
      busy_d = 1'b1;
      slot_d = '0;
    end else if (busy) begin
      if (at_final) begin
        busy_d = 1'b0;
        slot_d = '0;
      end else begin
        slot_d = slot + {{(SLOT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
    end else begin
      busy <= busy_d;
      slot <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt <= FMT_LEVEL;
    end else if (fmt_en) begin
      fmt <= fmt_e'(fmt_in);
    end
  end

endmodule

// File: rtl/brz_slot_mux.sv
// Picks the drive code for the current tick.
module brz_slot_mux
  import brz_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input  logic              busy,
  input  logic [SLOT_W-1:0] slot,
  input  fmt_e              fmt,
  input  logic [CODE_W-1:0] pos_code,
  input  logic [CODE_W-1:0] neg_code,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    code = '0;
    if (busy) begin
      case (fmt)
        FMT_LEVEL:  code = pos_code;
        FMT_DOUBLE: code = (slot == 2'd0) ? pos_code : neg_code;
        default: begin
          case (slot)
            2'd0:    code = pos_code;
            2'd2:    code = neg_code;
            default: code = '0;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/bipolar_rz_encoder.sv
module bipolar_rz_encoder
  import brz_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              pix_ready,
  output logic [CODE_W-1:0] dac_code
);

  logic              seq_accept;
  logic              seq_busy;
  logic [SLOT_W-1:0] seq_slot;
  fmt_e              seq_fmt;
  logic [PIX_W-1:0]  pix_q;
  logic [CODE_W-1:0] code_pos;
  logic [CODE_W-1:0] code_neg;

  brz_slot_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (pix_valid),
    .fmt_in   (fmt_sel),
    .in_ready (pix_ready),
    .accept   (seq_accept),
    .busy     (seq_busy),
    .slot     (seq_slot),
    .fmt      (seq_fmt)
  );

  // Pixel holding register, loaded on acceptance only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
    end else if (seq_accept) begin
      pix_q <= pix_data;
    end
  end

  brz_code_map #(.PIX_W(PIX_W), .CODE_W(CODE_W)) u_map (
    .pix      (pix_q),
    .pos_code (code_pos),
    .neg_code (code_neg)
  );

  brz_slot_mux #(.CODE_W(CODE_W)) u_mux (
    .busy     (seq_busy),
    .slot     (seq_slot),
    .fmt      (seq_fmt),
    .pos_code (code_pos),
    .neg_code (code_neg),
    .code     (dac_code)
  );

endmodule

// File: rtl/brz_checker.sv
module brz_checker
  import brz_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [CODE_W-1:0] dac_code,
  input logic              busy,
  input logic [SLOT_W-1:0] slot,
  input logic [1:0]        fmt
);

  function automatic logic [CODE_W-1:0] inv_sat(input logic [CODE_W-1:0] x);
    if (x == {1'b1, {(CODE_W-1){1'b0}}}) return {1'b0, {(CODE_W-1){1'b1}}};
    return (~x) + {{(CODE_W-1){1'b0}}, 1'b1};
  endfunction

  // R8: nothing in progress means zero drive.
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0 && pix_ready));

  // R6: a stalled pixel keeps running without a new acceptance.
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pix_ready) |=> busy);

  // R7: format stays fixed while no acceptance happens.
  p_fmt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(pix_valid && pix_ready)) |=> $stable(fmt));

  // R3: second tick of a return-to-zero pixel is zero.
  p_rz_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fmt[1] && slot == 2'd0) |=> dac_code == '0);

  // R2: second tick of a doubled pixel inverts the first.
  p_double_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fmt == 2'd1 && slot == 2'd0) |=> dac_code == inv_sat($past(dac_code)));

  // R1: level pixels always end on their only tick.
  p_level_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fmt == 2'd0) |-> pix_ready);

endmodule

bind bipolar_rz_encoder brz_checker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .dac_code  (dac_code),
  .busy      (seq_busy),
  .slot      (seq_slot),
  .fmt       (seq_fmt)
);

// File: tb/bipolar_rz_encoder_test.sv
`timescale 1ns/1ps
module bipolar_rz_encoder_test;

  logic        clk;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic        pix_valid;
  logic [7:0]  pix_data;
  logic        pix_ready;
  logic [13:0] dac_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pend[$];

  bipolar_rz_encoder uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .dac_code(dac_code)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int code_of(int p);
    return (p - 128) * 64;
  endfunction

  function automatic int inv_of(int v);
    return (v == -8192) ? 8191 : -v;
  endfunction

  // Reference model: queue of codes still to be played for the current pixel.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend.delete();
    end else begin
      if (pix_valid && (pend.size() <= 1)) begin
        int v;
        v = code_of(int'(pix_data));
        pend.delete();
        pend.push_back(v);
        if (fmt_sel == 2'd1) begin
          pend.push_back(inv_of(v));
        end else if (fmt_sel[1]) begin
          pend.push_back(0);
          pend.push_back(inv_of(v));
          pend.push_back(0);
        end
      end else if (pend.size() > 0) begin
        void'(pend.pop_front());
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-tick comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ec;
      ec = (pend.size() > 0) ? pend[0] : 0;
      check((pend.size() > 0) ? "R1/R2/R3 code" : "R8 idle code",
            int'($signed(dac_code)), ec);
      check("R6 ready", int'(pix_ready), (pend.size() <= 1) ? 1 : 0);
    end
  end

  task automatic drive(input bit v, input int p, input int f);
    @(negedge clk);
    #1;
    pix_valid = v;
    pix_data  = 8'(p);
    fmt_sel   = 2'(f);
  endtask

  task automatic expect_code(input string req, input int exp);
    @(negedge clk);
    check(req, int'($signed(dac_code)), exp);
  endtask

  initial begin
    int ticks = 0;
    while (!done && ticks < 100000) begin
      @(posedge clk);
      ticks++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pix_valid = 0; pix_data = 0; fmt_sel = 0;
    #3;
    check("R8 reset code", int'($signed(dac_code)), 0);
    check("R8 reset ready", int'(pix_ready), 1);
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    // R4 and R1: level mapping, back to back.
    drive(1, 0, 0);
    expect_code("R4 pixel 0", -8192);
    #1 pix_data = 8'd128;
    expect_code("R4 pixel 128", 0);
    #1 pix_data = 8'd255;
    expect_code("R4 pixel 255", 8128);
    #1 pix_data = 8'd10; fmt_sel = 2'd1;
    expect_code("R1 back-to-back", (10 - 128) * 64);
    // Doubled pixel 10 running, then feed 0 for the saturation case.
    #1 pix_data = 8'd0;
    expect_code("R2 inverted", (128 - 10) * 64);
    expect_code("R2 first tick", -8192);
    expect_code("R5 saturated inversion", 8191);
    #1 pix_valid = 0;
    expect_code("R8 idle after doubled", 0);

    // R7: format changes while a return-to-zero pixel runs.
    drive(1, 200, 2);
    expect_code("R3 first pulse", 4608);
    #1 fmt_sel = 2'd0;
    expect_code("R7 zero tick kept", 0);
    expect_code("R7 inverted pulse kept", -4608);
    expect_code("R3 trailing zero", 0);
    expect_code("R1 new level pixel", 4608);
    #1 pix_valid = 0;

    // fmt 3 behaves as return-to-zero.
    drive(1, 64, 3);
    expect_code("R3 alt first", -4096);
    #1 pix_valid = 0;
    expect_code("R3 alt zero", 0);
    expect_code("R3 alt inverted", 4096);
    expect_code("R3 alt zero end", 0);

    // Random traffic checked by the per-tick model.
    for (int i = 0; i < 2000; i++) begin
      drive(($urandom % 3) != 0, int'($urandom % 256), int'($urandom % 4));
    end
    drive(0, 0, 0);
    repeat (6) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule